// File: doc/BRIEF.md
# Double-Buffered Serial Frame Transmitter

This block sends characters as asynchronous serial frames. A one-entry holding register sits in front of the frame shifter. A write strobe loads that register, and the shifter takes the character from it. When the shifter is idle, the load happens one clock after the write. When a frame is in flight and another character is waiting, the shifter takes the waiting character on the same clock edge that ends the last stop bit. Back-to-back characters therefore leave the line with no idle bit between them.

The frame format is chosen by three inputs. A size code selects 5 to 9 data bits. A parity mode selects no parity, even parity or odd parity. A stop select picks one or two stop bits. The ninth data bit does not come from the write port. It comes from a separate staging register, which must be written before the character. An external baud tick paces the frame, and each bit lasts a fixed number of ticks. An enable input gives the pin to the transmitter; while the enable is low, the pin shows a default level.

Three status outputs report the block's state. One shows that the holding register is empty. One shows that the line has drained. One flags that a pending character was overwritten.

The frame shifter is a state machine with five states:
- ST_IDLE: the line is high. It moves to ST_START when a character is held (a load).
- ST_START: sends the start bit. It moves to ST_DATA when the bit ends.
- ST_DATA: sends the data bits. It stays in ST_DATA for each data bit. After the last data bit it moves to ST_PARITY if parity is on, and to ST_STOP if it is not.
- ST_PARITY: sends the parity bit. It moves to ST_STOP when the bit ends.
- ST_STOP: sends the stop bits. At the end of the final stop bit it moves to ST_START if a character is waiting (a reload). If none is waiting, it moves to ST_IDLE and sets the done flag.

Top module: `dbl_buf_uart_tx`

## Requirements
- R1: After reset, the status outputs read as follows: buf_empty is 1, tx_done is 0 and ovr_flag is 0. The line is idle, so txd is 1 while tx_enable is 1.
- R2: A frame is sent in this order: one start bit at 0, the data bits least significant first, the optional parity bit, and then the stop bits at 1. Each bit lasts 16 baud ticks. Ticks that arrive while the line is idle have no effect, and txd stays high.
- R3: The size code sets the number of data bits. Codes 0, 1, 2 and 3 give 5, 6, 7 and 8 bits. Codes 4, 5 and 6 give 8 bits. Code 7 gives 9 bits. In 9-bit mode, bit 8 is the ninth_val that was staged by ninth_wr on a cycle before the character write.
- R4: The parity mode works as follows. Value 0 or 3 sends no parity bit. Value 1 sends even parity, which is the XOR of the data bits that are sent. Value 2 sends odd parity, which is that XOR inverted.
- R5: When two_stop is 0, the frame ends with one stop bit. When two_stop is 1, it ends with two.
- R6: Suppose a write is sampled at clock edge k while the line is idle. The character is loaded at edge k+1, and the start bit appears on txd after that edge.
- R7: A character written during a frame is loaded at the edge that ends the final stop bit. Its start bit follows at once, with no idle bit.
- R8: buf_empty goes to 0 on the edge after a write. It returns to 1 on the edge at which the shifter takes the character, unless a new write is sampled on that same edge.
- R9: tx_done goes to 1 when the final stop bit ends and no character is waiting. Any write clears it on the next edge, and the write has priority.
- R10: A write while a character is waiting and not being loaded replaces that character and sets ovr_flag. Any other write clears ovr_flag.
- R11: While tx_enable is 0, txd equals port_default. The frame timing continues, so after tx_enable returns to 1, txd shows the bit that is then in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character bits 7..0 |
| ninth_wr | input | 1 | Strobe that stages ninth_val |
| ninth_val | input | 1 | Value for data bit 8 in 9-bit mode |
| size_code | input | 3 | Data bit count select |
| parity_mode | input | 2 | 0/3 none, 1 even, 2 odd |
| two_stop | input | 1 | 1 selects two stop bits |
| tx_enable | input | 1 | Gives the pin to the transmitter |
| port_default | input | 1 | Pin level while the transmitter is disabled |
| baud_tick | input | 1 | Bit pacing strobe, 16 per bit |
| txd | output | 1 | Serial output pin |
| buf_empty | output | 1 | Holding register is free |
| tx_done | output | 1 | Last frame finished with nothing waiting |
| ovr_flag | output | 1 | Last write replaced a waiting character |

## Verification
A wrong bit counter or a wrong parity register shows up on txd within one bit time. It appears as a misplaced edge or a wrong level at the point where the reference frame changes. A missed reload shows up as an extra high bit, or a late start bit, at the boundary between two frames. A lost holding-register state shows on buf_empty or ovr_flag on the very next edge after the write or load that should have changed it. The reference model is compared with all four outputs on every clock, so a divergence is caught in the cycle it first becomes visible.

// File: rtl/dbtx_pkg.sv
package dbtx_pkg;
    localparam int SIZE_W = 3;
    localparam int PAR_W  = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_t;

    typedef enum logic [1:0] {
        PAR_OFF  = 2'd0,
        PAR_EVEN = 2'd1,
        PAR_ODD  = 2'd2,
        PAR_OFF2 = 2'd3
    } par_mode_t;
endpackage

// File: rtl/dbtx_hold_buf.sv
module dbtx_hold_buf #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CHAR_W-1:0] wr_data,
    input  logic              ninth_wr,
    input  logic              ninth_val,
    input  logic              take,
    output logic [CHAR_W:0]   hold_word,
    output logic              hold_valid,
    output logic              ovr
);
    logic ninth_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ninth_q    <= 1'b0;
            hold_word  <= '0;
            hold_valid <= 1'b0;
            ovr        <= 1'b0;
        end else begin
            if (ninth_wr) ninth_q <= ninth_val;
            if (wr_en) begin
                hold_word  <= {ninth_q, wr_data};
                hold_valid <= 1'b1;
                ovr        <= hold_valid && !take;
            end else if (take) begin
                hold_valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dbtx_frame_fmt.sv
module dbtx_frame_fmt
    import dbtx_pkg::*;
#(
    parameter int CHAR_W = 8,
    localparam int MAX_BITS = CHAR_W + 1,
    localparam int CNT_W = $clog2(MAX_BITS + 1)
) (
    input  logic [MAX_BITS-1:0] word,
    input  logic [SIZE_W-1:0]   size_code,
    input  logic [PAR_W-1:0]    parity_mode,
    output logic [MAX_BITS-1:0] data_bits,
    output logic [CNT_W-1:0]    nbits,
    output logic                par_en,
    output logic                par_bit
);
    logic [MAX_BITS-1:0] mask;

    always_comb begin
        case (size_code)
            3'd0, 3'd1, 3'd2, 3'd3: nbits = CNT_W'(CHAR_W - 3) + CNT_W'(size_code);
            3'd7:                   nbits = CNT_W'(MAX_BITS);
            default:                nbits = CNT_W'(CHAR_W);
        endcase
        for (int i = 0; i < MAX_BITS; i++) begin
            mask[i] = CNT_W'(i) < nbits;
        end
        data_bits = word & mask;
        par_en    = (parity_mode == PAR_EVEN) || (parity_mode == PAR_ODD);
        par_bit   = (^data_bits) ^ (parity_mode == PAR_ODD);
    end
endmodule

// File: rtl/dbtx_shift_fsm.sv
module dbtx_shift_fsm
    import dbtx_pkg::*;
#(
    parameter int CHAR_W = 8,
    parameter int TICKS  = 16,
    localparam int MAX_BITS = CHAR_W + 1,
    localparam int CNT_W = $clog2(MAX_BITS + 1),
    localparam int TICK_W = $clog2(TICKS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                baud_tick,
    input  logic                wr_en,
    input  logic                hold_valid,
    input  logic [MAX_BITS-1:0] fmt_data,
    input  logic [CNT_W-1:0]    fmt_nbits,
    input  logic                fmt_par_en,
    input  logic                fmt_par_bit,
    input  logic                two_stop,
    output logic                load,
    output logic                line,
    output logic                done
);
    tx_state_t           state_q, state_d;
    logic [TICK_W-1:0]   tick_cnt;
    logic [MAX_BITS-1:0] sreg;
    logic [CNT_W-1:0]    bits_left;
    logic [1:0]          stop_left;
    logic                par_en_q, par_q, two_q;
    logic                bit_end, finish;

    assign bit_end = baud_tick && (tick_cnt == TICK_W'(TICKS - 1));

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        finish  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (hold_valid) begin
                    load    = 1'b1;
                    state_d = ST_START;
                end
            end
            ST_START: if (bit_end) state_d = ST_DATA;
            ST_DATA: begin
                if (bit_end && bits_left == CNT_W'(1))
                    state_d = par_en_q ? ST_PARITY : ST_STOP;
            end
            ST_PARITY: if (bit_end) state_d = ST_STOP;
            ST_STOP: begin
                if (bit_end && stop_left == 2'd1) begin
                    if (hold_valid) begin
                        load    = 1'b1;
                        state_d = ST_START;
                    end else begin
                        finish  = 1'b1;
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_cnt  <= '0;
            sreg      <= '0;
            bits_left <= '0;
            stop_left <= 2'd0;
            par_en_q  <= 1'b0;
            par_q     <= 1'b0;
            two_q     <= 1'b0;
            done      <= 1'b0;
        end else begin
            if (load) begin
                tick_cnt  <= '0;
                sreg      <= fmt_data;
                bits_left <= fmt_nbits;
                par_en_q  <= fmt_par_en;
                par_q     <= fmt_par_bit;
                two_q     <= two_stop;
            end else begin
                if (state_q != ST_IDLE && baud_tick)
                    tick_cnt <= bit_end ? '0 : tick_cnt + TICK_W'(1);
                if (state_q == ST_DATA && bit_end) begin
                    sreg      <= sreg >> 1;
                    bits_left <= bits_left - CNT_W'(1);
                end
                if (state_d == ST_STOP && state_q != ST_STOP)
                    stop_left <= two_q ? 2'd2 : 2'd1;
                else if (state_q == ST_STOP && bit_end)
                    stop_left <= stop_left - 2'd1;
            end
            if (wr_en)       done <= 1'b0;
            else if (finish) done <= 1'b1;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_START:  line = 1'b0;
            ST_DATA:   line = sreg[0];
            ST_PARITY: line = par_q;
            default:   line = 1'b1;
        endcase
    end
endmodule

// File: rtl/dbl_buf_uart_tx.sv
module dbl_buf_uart_tx
    import dbtx_pkg::*;
#(
    parameter int CHAR_W = 8,
    parameter int TICKS  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CHAR_W-1:0] wr_data,
    input  logic              ninth_wr,
    input  logic              ninth_val,
    input  logic [2:0]        size_code,
    input  logic [1:0]        parity_mode,
    input  logic              two_stop,
    input  logic              tx_enable,
    input  logic              port_default,
    input  logic              baud_tick,
    output logic              txd,
    output logic              buf_empty,
    output logic              tx_done,
    output logic              ovr_flag
);
    localparam int MAX_BITS = CHAR_W + 1;
    localparam int CNT_W = $clog2(MAX_BITS + 1);

    logic [MAX_BITS-1:0] hold_word, fmt_data;
    logic [CNT_W-1:0]    fmt_nbits;
    logic                hold_valid, fmt_par_en, fmt_par_bit, load_w, line_w;

    dbtx_hold_buf #(.CHAR_W(CHAR_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .ninth_wr(ninth_wr), .ninth_val(ninth_val), .take(load_w),
        .hold_word(hold_word), .hold_valid(hold_valid), .ovr(ovr_flag)
    );

    dbtx_frame_fmt #(.CHAR_W(CHAR_W)) u_fmt (
        .word(hold_word), .size_code(size_code), .parity_mode(parity_mode),
        .data_bits(fmt_data), .nbits(fmt_nbits),
        .par_en(fmt_par_en), .par_bit(fmt_par_bit)
    );

    dbtx_shift_fsm #(.CHAR_W(CHAR_W), .TICKS(TICKS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
        .hold_valid(hold_valid), .fmt_data(fmt_data), .fmt_nbits(fmt_nbits),
        .fmt_par_en(fmt_par_en), .fmt_par_bit(fmt_par_bit), .two_stop(two_stop),
        .load(load_w), .line(line_w), .done(tx_done)
    );

    assign buf_empty = !hold_valid;
    assign txd       = tx_enable ? line_w : port_default;
endmodule

// File: rtl/dbtx_checker.sv
module dbtx_checker (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic baud_tick,
    input logic tx_enable,
    input logic load,
    input logic txd,
    input logic buf_empty,
    input logic tx_done,
    input logic ovr_flag
);
    AST_TXD_HOLDS_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_enable && $past(tx_enable) && !$past(baud_tick) && !$past(load)) |-> $stable(txd)); // R2

    AST_EMPTY_CLEARS_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !buf_empty); // R8

    AST_DONE_CLEARS_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !tx_done); // R9

    AST_DONE_ONLY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> buf_empty); // R9

    AST_OVR_NEEDS_FULL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_flag) |-> ($past(wr_en) && !$past(buf_empty))); // R10
endmodule

bind dbl_buf_uart_tx dbtx_checker u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .baud_tick(baud_tick),
    .tx_enable(tx_enable), .load(load_w), .txd(txd), .buf_empty(buf_empty),
    .tx_done(tx_done), .ovr_flag(ovr_flag)
);

// File: tb/dbl_buf_uart_tx_test.sv
`timescale 1ns/1ps
module dbl_buf_uart_tx_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       ninth_wr = 1'b0, ninth_val = 1'b0;
    logic [2:0] size_code = 3'd3;
    logic [1:0] parity_mode = 2'd0;
    logic       two_stop = 1'b0, tx_enable = 1'b0, port_default = 1'b0;
    logic       baud_tick = 1'b0;
    logic       txd, buf_empty, tx_done, ovr_flag;

    int checks = 0, errors = 0, cycles = 0, tick_div = 1, tick_ph = 0;
    string cur_req = "R2";

    // reference model state
    int   q[$];
    int   tcnt = 0;
    logic pend = 0, done_m = 0, ovr_m = 0, ninth_m = 0;
    logic [8:0] hold_m = '0;

    always #2 clk = ~clk;

    dbl_buf_uart_tx uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .ninth_wr(ninth_wr), .ninth_val(ninth_val), .size_code(size_code),
        .parity_mode(parity_mode), .two_stop(two_stop), .tx_enable(tx_enable),
        .port_default(port_default), .baud_tick(baud_tick), .txd(txd),
        .buf_empty(buf_empty), .tx_done(tx_done), .ovr_flag(ovr_flag)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic build_frame();
        int nb, p;
        nb = (size_code < 3'd4) ? int'(size_code) + 5 : (size_code == 3'd7) ? 9 : 8;
        p = 0;
        q.push_back(0);
        for (int i = 0; i < nb; i++) begin
            q.push_back(int'(hold_m[i]));
            p ^= int'(hold_m[i]);
        end
        if (parity_mode == 2'd1) q.push_back(p);
        if (parity_mode == 2'd2) q.push_back(p ^ 1);
        q.push_back(1);
        if (two_stop) q.push_back(1);
        tcnt = 0;
    endtask

    always @(negedge clk) begin
        tick_ph = (tick_ph + 1) % tick_div;
        baud_tick = (tick_ph == 0);
    end

    always @(posedge clk) begin
        logic ld;
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            summary();
        end
        ld = 0;
        if (!rst_n) begin
            q.delete(); tcnt = 0; pend = 0; done_m = 0; ovr_m = 0; ninth_m = 0; hold_m = '0;
        end else begin
            if (q.size() > 0) begin
                if (baud_tick) begin
                    tcnt++;
                    if (tcnt == 16) begin
                        tcnt = 0;
                        void'(q.pop_front());
                        if (q.size() == 0) begin
                            if (pend) ld = 1;
                            else done_m = 1;
                        end
                    end
                end
            end else if (pend) ld = 1;
            if (wr_en) ovr_m = pend && !ld;
            if (ld) begin
                build_frame();
                pend = 0;
            end
            if (wr_en) begin
                hold_m = {ninth_m, wr_data};
                pend = 1;
                done_m = 0;
            end
            if (ninth_wr) ninth_m = ninth_val;
        end
        #1;
        if (rst_n) begin
            chk(cur_req, int'(txd), tx_enable ? ((q.size() > 0) ? q[0] : 1) : int'(port_default));
            chk("R8", int'(buf_empty), int'(!pend));
            chk("R9", int'(tx_done), int'(done_m));
            chk("R10", int'(ovr_flag), int'(ovr_m));
        end
    end

    task automatic do_write(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        do @(posedge clk); while (q.size() > 0 || pend);
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        // R1 reset state, pin handed to port default while disabled
        chk("R1", int'(buf_empty), 1);
        chk("R1", int'(tx_done), 0);
        chk("R1", int'(ovr_flag), 0);
        chk("R1", int'(txd), 0);
        @(negedge clk); tx_enable = 1'b1;
        @(posedge clk); #1;
        chk("R1", int'(txd), 1);
        repeat (40) @(posedge clk);          // R2 idle ticks ignored

        // R2 R4 R6: 8 bits, even parity, one stop
        cur_req = "R6"; parity_mode = 2'd1;
        do_write(8'hA5);
        @(posedge clk); #1;
        chk("R6", int'(txd), 0);
        chk("R8", int'(buf_empty), 1);
        cur_req = "R4";
        wait_idle();
        chk("R9", int'(tx_done), 1);

        // R3 R5: 5 bits, odd parity, two stop bits
        cur_req = "R5"; size_code = 3'd0; parity_mode = 2'd2; two_stop = 1'b1;
        do_write(8'hF3);
        wait_idle();

        // R3: 9-bit mode, ninth bit staged first, even parity
        cur_req = "R3"; size_code = 3'd7; parity_mode = 2'd1; two_stop = 1'b0;
        @(negedge clk); ninth_wr = 1'b1; ninth_val = 1'b1;
        @(negedge clk); ninth_wr = 1'b0;
        do_write(8'h3C);
        wait_idle();

        // R3: code 5 acts as 8 bits, parity mode 3 means none
        size_code = 3'd5; parity_mode = 2'd3;
        do_write(8'h81);
        wait_idle();

        // R7: gapless back-to-back, slower tick
        cur_req = "R7"; tick_div = 3; size_code = 3'd2; parity_mode = 2'd0;
        do_write(8'h55);
        repeat (10) @(negedge clk);
        do_write(8'h2A);
        chk("R8", int'(buf_empty), 0);
        wait_idle();
        tick_div = 1;

        // R10 overrun replaces pending character
        cur_req = "R10"; size_code = 3'd3;
        do_write(8'h11);
        repeat (5) @(negedge clk);
        do_write(8'h22);
        chk("R10", int'(ovr_flag), 0);
        do_write(8'h33);
        chk("R10", int'(ovr_flag), 1);
        wait_idle();
        do_write(8'h44);
        chk("R10", int'(ovr_flag), 0);
        wait_idle();

        // R11 disable mid-frame
        cur_req = "R11";
        do_write(8'h0F);
        repeat (30) @(negedge clk);
        tx_enable = 1'b0; port_default = 1'b1;
        @(posedge clk); #1;
        chk("R11", int'(txd), 1);
        @(negedge clk); port_default = 1'b0;
        @(posedge clk); #1;
        chk("R11", int'(txd), 0);
        repeat (20) @(negedge clk);
        tx_enable = 1'b1;
        wait_idle();
        summary();
    end
endmodule